// File: doc/BRIEF.md
# Bit-Serial Rank Selection Filter

This block returns the r-th largest of N unsigned B-bit samples. It does not sort. It works on one bit plane per clock, starting at the most significant plane. On each plane it counts how many samples hold a 1 in that position. That count sets the output bit: the bit is 1 when the count is at least r. Each sample whose bit on that plane disagrees with the chosen output bit then has every lower bit forced to the value of its own bit on that plane. A sample that is already known to be below the answer therefore drops out of all later counts as zero. A sample already known to be above it keeps counting as one. Each decided bit shifts into a result register. One cycle after the last plane, the finished value is copied to the output.

The sample set enters through a valid/ready handshake. All N samples and the rank are presented together on one beat. Ready is low while bit planes are being scanned, so an offered set waits without being taken. The block never buffers a second set. The output side has no back-pressure: `out_valid` is a single-cycle pulse, and `out_result` holds its value until the next pulse. Ready rises again in the copy cycle, so a waiting set can be taken on the same edge that publishes the previous result. In steady state this gives one result every B+1 cycles.

Top module: `rof_rank_filter`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_result` is 0. Whenever no scan is in progress, `in_ready` is 1.
- R2: A set is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 1 in exactly the cycle that follows the (B+1)-th rising edge after the accepting edge.
- R3: `out_valid` never stays high for two consecutive cycles.
- R4: `out_result` changes only in cycles where `out_valid` is 1, and holds its value between pulses.
- R5: `in_ready` is 0 in the B cycles that follow an accepting edge. A set offered during that window is not taken and not queued unless it is still offered when `in_ready` returns. The result of the scan in progress is unaffected by it.
- R6: For a rank r in 1..N, the result is the largest value v such that at least r samples are greater than or equal to v. Duplicate samples count separately.
- R7: Rank 1 returns the maximum, rank N returns the minimum, and rank (N+1)/2 returns the median for odd N.
- R8: With N=7 and B=4, the samples 7, 5, 11, 14, 2, 8, 3 at rank 1 give 14 (binary 1110).
- R9: A set offered in the cycle before an `out_valid` pulse is accepted on the edge that raises that pulse. Both results are correct, and their pulses are B+1 cycles apart.
- R10: Sample i sits at `in_samples[i*B +: B]`. The rank is an unsigned number in 1..N, captured on the accepting edge. A change of `in_rank` or `in_samples` after that edge has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A sample set and rank are offered |
| in_ready | output | 1 | The block can take a set on this edge |
| in_samples | input | N*B | N packed unsigned samples, sample i at bits i*B upward |
| in_rank | input | $clog2(N+1) | Rank r, 1 = largest |
| out_valid | output | 1 | One-cycle pulse: `out_result` was just updated |
| out_result | output | B | Most recent selected sample value |

## Verification
Publishing a finished result and accepting the next sample set can happen on the same clock edge. In that cycle the result register is read for copying while it is also being cleared for the new scan. The bench provokes the overlap by holding `in_valid` high with a second set throughout a scan. It then checks two things: that the first pulse carries the first set's answer, and that a second pulse follows exactly B+1 cycles later with the second set's answer. A companion case drops the offered set before ready returns, and checks that no second pulse appears and that the published value stays unchanged.

// File: rtl/rof_pkg.sv
package rof_pkg;

  typedef enum logic [1:0] {
    ROF_IDLE    = 2'd0,
    ROF_SCAN    = 2'd1,
    ROF_PUBLISH = 2'd2
  } rof_state_e;

endpackage

// File: rtl/rof_ctrl.sv
module rof_ctrl
  import rof_pkg::*;
#(
  parameter int B  = 4,
  parameter int PW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  output logic          accept,
  output logic          scan,
  output logic          publish,
  output logic [PW-1:0] plane
);

  localparam logic [PW-1:0] TOP_PLANE = PW'(B - 1);

  rof_state_e    state_q, state_d;
  logic [PW-1:0] plane_q, plane_d;

  // ready is withheld only while planes are being resolved
  assign in_ready = (state_q != ROF_SCAN);
  assign accept   = in_valid && in_ready;
  assign scan     = (state_q == ROF_SCAN);
  assign publish  = (state_q == ROF_PUBLISH);
  assign plane    = plane_q;

  always_comb begin
    state_d = state_q;
    plane_d = plane_q;
    unique case (state_q)
      ROF_SCAN: begin
        if (plane_q == '0) begin
          state_d = ROF_PUBLISH;
        end else begin
          plane_d = plane_q - 1'b1;
        end
      end
      ROF_PUBLISH: state_d = ROF_IDLE;
      default:     state_d = ROF_IDLE;
    endcase
    if (accept) begin
      state_d = ROF_SCAN;
      plane_d = TOP_PLANE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ROF_IDLE;
      plane_q <= '0;
    end else begin
      state_q <= state_d;
      plane_q <= plane_d;
    end
  end

endmodule

// File: rtl/rof_threshold.sv
module rof_threshold #(
  parameter int N  = 7,
  parameter int B  = 4,
  parameter int RW = 3,
  parameter int PW = 2
) (
  input  logic [N*B-1:0] bank,
  input  logic [PW-1:0]  plane,
  input  logic [RW-1:0]  rank,
  output logic           decide
);

  logic [N-1:0]  column;
  logic [RW-1:0] ones;

  // slice the selected plane out of every sample
  for (genvar g = 0; g < N; g++) begin : g_col
    logic [B-1:0] word;
    assign word      = bank[g*B +: B];
    assign column[g] = word[plane];
  end

  always_comb begin
    ones = '0;
    for (int i = 0; i < N; i++) begin
      ones = ones + RW'(column[i]);
    end
    decide = (ones >= rank);
  end

endmodule

// File: rtl/rof_polarizer.sv
module rof_polarizer #(
  parameter int B  = 4,
  parameter int PW = 2
) (
  input  logic [B-1:0]  smp,
  input  logic [PW-1:0] plane,
  input  logic          bit_y,
  output logic [B-1:0]  nxt
);

  logic own_bit;
  logic flip;

  assign own_bit = smp[plane];
  assign flip    = (own_bit != bit_y);

  // a disagreeing sample is pinned: all lower planes copy its own bit
  always_comb begin
    nxt = smp;
    for (int j = 0; j < B; j++) begin
      if (flip && (j < int'(plane))) begin
        nxt[j] = own_bit;
      end
    end
  end

endmodule

// File: rtl/rof_rank_filter.sv
module rof_rank_filter #(
  parameter  int N  = 7,
  parameter  int B  = 4,
  localparam int RW = $clog2(N + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [N*B-1:0] in_samples,
  input  logic [RW-1:0]  in_rank,
  output logic           out_valid,
  output logic [B-1:0]   out_result
);

  localparam int PW = (B > 1) ? $clog2(B) : 1;

  logic           accept;
  logic           scan;
  logic           publish;
  logic [PW-1:0]  plane;
  logic [N*B-1:0] bank_q;
  logic [N*B-1:0] bank_d;
  logic [RW-1:0]  rank_q;
  logic           y_bit;
  logic [B-1:0]   shreg_q;

  rof_ctrl #(.B(B), .PW(PW)) ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .accept   (accept),
    .scan     (scan),
    .publish  (publish),
    .plane    (plane)
  );

  rof_threshold #(.N(N), .B(B), .RW(RW), .PW(PW)) thr_i (
    .bank   (bank_q),
    .plane  (plane),
    .rank   (rank_q),
    .decide (y_bit)
  );

  for (genvar g = 0; g < N; g++) begin : g_pol
    rof_polarizer #(.B(B), .PW(PW)) pol_i (
      .smp   (bank_q[g*B +: B]),
      .plane (plane),
      .bit_y (y_bit),
      .nxt   (bank_d[g*B +: B])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q     <= '0;
      rank_q     <= '0;
      shreg_q    <= '0;
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      if (accept) begin
        bank_q  <= in_samples;
        rank_q  <= in_rank;
        shreg_q <= '0;
      end else if (scan) begin
        bank_q  <= bank_d;
        shreg_q <= {shreg_q[B-2:0], y_bit};
      end
      out_valid <= publish;
      if (publish) begin
        out_result <= shreg_q;
      end
    end
  end

endmodule

// File: rtl/rof_rank_filter_chk.sv
module rof_rank_filter_chk #(
  parameter int B = 4
) (
  input logic         clk,
  input logic         rst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic         out_valid,
  input logic [B-1:0] out_result
);

  localparam int CW = $clog2(B + 2);

  logic [CW-1:0] pend_q;
  logic          due_q;

  // cycles left until publication, counted from the handshake alone
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      due_q  <= 1'b0;
    end else begin
      due_q <= (pend_q == CW'(1));
      if (in_valid && in_ready) begin
        pend_q <= CW'(B + 1);
      end else if (pend_q != '0) begin
        pend_q <= pend_q - 1'b1;
      end
    end
  end

  // R2
  latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == due_q);

  // R5
  busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q > CW'(1)) |-> !in_ready);

  // R1
  idle_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q <= CW'(1)) |-> in_ready);

  // R3
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R4
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_result));

endmodule

bind rof_rank_filter rof_rank_filter_chk #(.B(B)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_result (out_result)
);

// File: tb/rof_rank_filter_tb_top.sv
module rof_rank_filter_tb_top;

  localparam int N  = 7;
  localparam int B  = 4;
  localparam int RW = $clog2(N + 1);
  localparam int WD = 150000;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [N*B-1:0] in_samples = '0;
  logic [RW-1:0]  in_rank = '0;
  logic           out_valid;
  logic [B-1:0]   out_result;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  rof_rank_filter #(.N(N), .B(B)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_samples (in_samples),
    .in_rank    (in_rank),
    .out_valid  (out_valid),
    .out_result (out_result)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WD) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: act=%0d cycles exp=<%0d", cyc, WD);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic int smp_at(input logic [N*B-1:0] s, input int i);
    return int'(s[i*B +: B]);
  endfunction

  // largest v with at least r samples >= v
  function automatic int ref_rank(input logic [N*B-1:0] s, input int r);
    for (int v = (1 << B) - 1; v >= 0; v--) begin
      int cnt = 0;
      for (int i = 0; i < N; i++) if (smp_at(s, i) >= v) cnt++;
      if (cnt >= r) return v;
    end
    return 0;
  endfunction

  // descending sort, then index
  function automatic int sorted_at(input logic [N*B-1:0] s, input int k);
    int a[N];
    for (int i = 0; i < N; i++) a[i] = smp_at(s, i);
    for (int i = 1; i < N; i++) begin
      int t = a[i];
      int j = i - 1;
      while (j >= 0 && a[j] < t) begin
        a[j+1] = a[j];
        j--;
      end
      a[j+1] = t;
    end
    return a[k];
  endfunction

  function automatic logic [N*B-1:0] rand_set();
    logic [N*B-1:0] s;
    for (int i = 0; i < N; i++) s[i*B +: B] = B'($urandom_range(0, (1 << B) - 1));
    return s;
  endfunction

  // offer at a negedge, get accepted on the following edge, drop valid
  task automatic offer(input logic [N*B-1:0] s, input int r);
    @(negedge clk);
    in_valid   = 1'b1;
    in_samples = s;
    in_rank    = RW'(r);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // full operation with timing checks; expected value supplied by caller
  task automatic run_op(input logic [N*B-1:0] s, input int r, input int exp, input string tag);
    offer(s, r);
    check(in_ready == 1'b0, "R5 ready low while scanning", int'(in_ready), 0);
    repeat (B) @(negedge clk);
    check(out_valid == 1'b0, "R2 no early pulse", int'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R2 pulse after B+1 edges", int'(out_valid), 1);
    check(int'(out_result) == exp, tag, int'(out_result), exp);
    @(negedge clk);
    check(out_valid == 1'b0, "R3 single pulse", int'(out_valid), 0);
  endtask

  initial begin
    logic [N*B-1:0] s;
    logic [N*B-1:0] s2;
    int e1;
    int e2;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 reset ready", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 reset valid", int'(out_valid), 0);
    check(out_result == '0, "R1 reset result", int'(out_result), 0);

    // R8 reference set: 7,5,11,14,2,8,3 rank 1
    s = '0;
    s[0*B +: B] = 4'd7;  s[1*B +: B] = 4'd5;  s[2*B +: B] = 4'd11;
    s[3*B +: B] = 4'd14; s[4*B +: B] = 4'd2;  s[5*B +: B] = 4'd8;
    s[6*B +: B] = 4'd3;
    run_op(s, 1, 14, "R8 reference result");
    run_op(s, 4, 7, "R7 reference median");
    run_op(s, N, 2, "R7 reference minimum");

    // R6 ties: constant sets, every rank
    for (int v = 0; v < (1 << B); v++) begin
      for (int i = 0; i < N; i++) s[i*B +: B] = B'(v);
      for (int r = 1; r <= N; r++) run_op(s, r, v, "R6 equal samples");
    end

    // R6 random sweep over all ranks
    for (int k = 0; k < 300; k++) begin
      s = rand_set();
      for (int r = 1; r <= N; r++) run_op(s, r, ref_rank(s, r), "R6 rank select");
    end

    // R7 max / median / min against sort
    for (int k = 0; k < 40; k++) begin
      s = rand_set();
      run_op(s, 1, sorted_at(s, 0), "R7 maximum");
      run_op(s, (N + 1) / 2, sorted_at(s, (N - 1) / 2), "R7 median");
      run_op(s, N, sorted_at(s, N - 1), "R7 minimum");
    end

    // R9 overlap: second set held throughout the first scan
    for (int k = 0; k < 20; k++) begin
      s  = rand_set();
      s2 = rand_set();
      e1 = ref_rank(s, 2);
      e2 = ref_rank(s2, 5);
      offer(s, 2);
      in_valid   = 1'b1;
      in_samples = s2;
      in_rank    = RW'(5);
      repeat (B) @(negedge clk);
      check(in_ready == 1'b1, "R9 ready in copy cycle", int'(in_ready), 1);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b1, "R9 first pulse", int'(out_valid), 1);
      check(int'(out_result) == e1, "R9 first result", int'(out_result), e1);
      @(negedge clk);
      check(int'(out_result) == e1, "R4 result held", int'(out_result), e1);
      repeat (B) @(negedge clk);
      check(out_valid == 1'b1, "R9 second pulse spacing", int'(out_valid), 1);
      check(int'(out_result) == e2, "R9 second result", int'(out_result), e2);
      @(negedge clk);
    end

    // R5 / R10 ignored offer and rank change during scan
    for (int k = 0; k < 20; k++) begin
      s  = rand_set();
      e1 = ref_rank(s, 3);
      offer(s, 3);
      in_valid   = 1'b1;
      in_samples = ~s;
      in_rank    = RW'(1);
      repeat (B - 1) @(negedge clk);
      in_valid = 1'b0;
      repeat (2) @(negedge clk);
      check(out_valid == 1'b1, "R10 pulse after busy offer", int'(out_valid), 1);
      check(int'(out_result) == e1, "R10 captured rank and samples", int'(out_result), e1);
      for (int t = 0; t < 2 * B + 2; t++) begin
        @(negedge clk);
        check(out_valid == 1'b0, "R5 busy offer not queued", int'(out_valid), 0);
        check(int'(out_result) == e1, "R4 result unchanged", int'(out_result), e1);
      end
    end

    // R1 idle: nothing offered, nothing produced
    for (int t = 0; t < 10; t++) begin
      @(negedge clk);
      check(in_ready == 1'b1 && out_valid == 1'b0, "R1 idle",
            int'({in_ready, out_valid}), 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule